// File: doc/BRIEF.md
# Mode-Dependent Register Window Decoder

This block decodes accesses on the byte-wide processor bus of a framing device. It takes a chip select, an 8-bit address, read and write strobes, three address straps, two bus-mode pins and an active-low extended-mode pin. From these it decides whether an access reaches the device's 64-entry register file. It also decides which register is addressed, and whether a read drives the shared data bus or leaves it released.

The straps place a 64-byte window in the 256-byte address space. In extended mode the two upper straps pick one of four aligned windows. In legacy mode all three straps must match the top three address bits. The extended-mode pin and the bus-mode pins then hide parts of the window. Hidden registers behave as though the device were not selected. The outputs are the data-bus output enable, a one-hot write enable per register, the register index, a read-data mask and a multiplexed-bus flag. All outputs are registered one cycle after the strobe.

Top module: `regwin_decoder`

## Requirements
- R1: While rst_ni is low, oe_o, wr_en_o, reg_idx_o and mux_mode_o are 0 and rd_mask_o is FFh.
- R2: With sel_ni high, no read raises oe_o and no write raises any bit of wr_en_o.
- R3: With ext_ni low, an access hits when addr_i[7:6] equals strap_i[2:1]. strap_i[0] (strap S5) has no effect, and the register index is addr_i[5:0].
- R4: With ext_ni high, an access hits when addr_i[7:5] equals strap_i[2:0], and the register index is addr_i[5:0].
- R5: An access whose address lies outside the mapped window leaves oe_o low and wr_en_o all zero.
- R6: With ext_ni high, registers 25h–3Fh can be neither read nor written. Registers 20h–24h stay accessible.
- R7: With bus_mode_i = 2'b11 (bit 1 is P1, bit 0 is P0), registers 20h–3Fh can be neither read nor written.
- R8: With bus_mode_i = 2'b10, mux_mode_o is 1 and every register 00h–3Fh permitted by the extended-mode pin is accessible. For any other bus_mode_i value, mux_mode_o is 0.
- R9: oe_o is 1 only after a read strobe that hits an accessible register. wr_en_o has exactly bit reg_idx_o set after a write that hits, and is zero otherwise.
- R10: rd_mask_o is 7Fh after a hitting read of register 10h, and FFh in every other case, so bit 7 of that register always reads 0.
- R11: Outputs respond to strobes and addresses sampled at a rising clock edge, and do so only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low |
| addr_i | input | 8 | Bus address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| strap_i | input | 3 | Address straps; bit 0 is S5, bit 1 is S6, bit 2 is S7 |
| bus_mode_i | input | 2 | Bus-mode pins; bit 1 is P1, bit 0 is P0 |
| ext_ni | input | 1 | Extended mode, active low (high means legacy) |
| oe_o | output | 1 | Data-bus output enable |
| wr_en_o | output | 64 | One-hot register write enable |
| reg_idx_o | output | 6 | Index of the register accessed |
| rd_mask_o | output | 8 | Mask ANDed onto read data |
| mux_mode_o | output | 1 | Multiplexed bus mode selected |

## Verification
Accesses are tried in every strap setting in both modes. S5 is flipped in extended mode to show that it is ignored. In legacy mode the same flip moves the window, which separates a 64-byte match from a 32-byte one. A full 256-address sweep in several mode and bus settings covers three cases: a window edge, a hidden high register, and a register hidden only under P0=P1=1. Each case is told apart from a plain miss. Directed reads of register 10h against its neighbours isolate the bit-7 mask, and a check just before each clock edge shows the one-cycle output latency.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int ADDR_W    = 8;
  localparam int WIN_AW    = 6;
  localparam int STRAP_W   = 3;
  localparam int DATA_W    = 8;
  localparam int NREG      = 1 << WIN_AW;
  localparam int EXT_SEL_W = ADDR_W - WIN_AW;

  localparam logic [WIN_AW-1:0] EXT_FIRST  = 6'h25;
  localparam logic [WIN_AW-1:0] HIGH_FIRST = 6'h20;
  localparam logic [WIN_AW-1:0] B7_ZERO_RG = 6'h10;

  typedef enum logic [1:0] {
    BUS_P00 = 2'b00,
    BUS_P01 = 2'b01,
    BUS_MUX = 2'b10,
    BUS_BAD = 2'b11
  } bus_mode_e;
endpackage

// File: rtl/regwin_match.sv
module regwin_match
  import regwin_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               ext_mode_i,
  output logic               in_win_o,
  output logic [WIN_AW-1:0]  offset_o
);
  localparam int LEG_SEL_W = STRAP_W;

  logic ext_hit, leg_hit;

  // extended: lowest strap ignored, upper straps select a 64-byte window
  assign ext_hit  = addr_i[ADDR_W-1 -: EXT_SEL_W] == strap_i[STRAP_W-1 -: EXT_SEL_W];
  // legacy: all straps against the top address bits
  assign leg_hit  = addr_i[ADDR_W-1 -: LEG_SEL_W] == strap_i;
  assign in_win_o = ext_mode_i ? ext_hit : leg_hit;
  assign offset_o = addr_i[WIN_AW-1:0];
endmodule

// File: rtl/regwin_access.sv
module regwin_access
  import regwin_pkg::*;
(
  input  logic [WIN_AW-1:0] offset_i,
  input  logic              ext_mode_i,
  input  logic [1:0]        bus_mode_i,
  output logic              reg_ok_o,
  output logic              mux_mode_o
);
  logic ext_blocked, high_blocked;

  assign ext_blocked  = !ext_mode_i && (offset_i >= EXT_FIRST);
  assign high_blocked = (bus_mode_e'(bus_mode_i) == BUS_BAD) && (offset_i >= HIGH_FIRST);
  assign reg_ok_o     = !ext_blocked && !high_blocked;
  assign mux_mode_o   = bus_mode_e'(bus_mode_i) == BUS_MUX;
endmodule

// File: rtl/regwin_strobe.sv
module regwin_strobe
  import regwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [WIN_AW-1:0] offset_i,
  input  logic              mux_mode_i,
  output logic              oe_o,
  output logic [NREG-1:0]   wr_en_o,
  output logic [WIN_AW-1:0] reg_idx_o,
  output logic [DATA_W-1:0] rd_mask_o,
  output logic              mux_mode_o
);
  localparam logic [DATA_W-1:0] MASK_ALL = '1;
  localparam logic [DATA_W-1:0] MASK_B7  = {1'b0, {(DATA_W-1){1'b1}}};

  logic              rd_hit, wr_hit;
  logic [NREG-1:0]   wr_dec;

  assign rd_hit = hit_i && rd_i;
  assign wr_hit = hit_i && wr_i;

  for (genvar g = 0; g < NREG; g++) begin : g_wdec
    assign wr_dec[g] = wr_hit && (offset_i == WIN_AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o       <= 1'b0;
      wr_en_o    <= '0;
      reg_idx_o  <= '0;
      rd_mask_o  <= MASK_ALL;
      mux_mode_o <= 1'b0;
    end else begin
      oe_o       <= rd_hit;
      wr_en_o    <= wr_dec;
      reg_idx_o  <= (rd_hit || wr_hit) ? offset_i : '0;
      rd_mask_o  <= (rd_hit && offset_i == B7_ZERO_RG) ? MASK_B7 : MASK_ALL;
      mux_mode_o <= mux_mode_i;
    end
  end

  // R9
  oe_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> $past(rd_i));
  // R9
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  // R9
  wr_idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> wr_en_o[reg_idx_o]);
  // R10
  b7_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rd_mask_o == MASK_ALL));
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [1:0]         bus_mode_i,
  input  logic               ext_ni,
  output logic               oe_o,
  output logic [NREG-1:0]    wr_en_o,
  output logic [WIN_AW-1:0]  reg_idx_o,
  output logic [DATA_W-1:0]  rd_mask_o,
  output logic               mux_mode_o
);
  logic              ext_mode, in_win, reg_ok, mux_mode, hit;
  logic [WIN_AW-1:0] offset;

  assign ext_mode = !ext_ni;

  regwin_match u_match (
    .addr_i     (addr_i),
    .strap_i    (strap_i),
    .ext_mode_i (ext_mode),
    .in_win_o   (in_win),
    .offset_o   (offset)
  );

  regwin_access u_access (
    .offset_i   (offset),
    .ext_mode_i (ext_mode),
    .bus_mode_i (bus_mode_i),
    .reg_ok_o   (reg_ok),
    .mux_mode_o (mux_mode)
  );

  assign hit = !sel_ni && in_win && reg_ok;

  regwin_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .offset_i   (offset),
    .mux_mode_i (mux_mode),
    .oe_o       (oe_o),
    .wr_en_o    (wr_en_o),
    .reg_idx_o  (reg_idx_o),
    .rd_mask_o  (rd_mask_o),
    .mux_mode_o (mux_mode_o)
  );

  // R2
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> (!oe_o && wr_en_o == '0));
  // R6
  legacy_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_ni && addr_i[WIN_AW-1:0] >= EXT_FIRST) |=> (!oe_o && wr_en_o == '0));
  // R7
  bad_bus_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_mode_i == 2'b11 && addr_i[WIN_AW-1:0] >= HIGH_FIRST) |=> (!oe_o && wr_en_o == '0));
  // R3
  ext_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_ni && addr_i[ADDR_W-1 -: 2] != strap_i[STRAP_W-1 -: 2]) |=> (!oe_o && wr_en_o == '0));
endmodule

// File: tb/tb_regwin_decoder.sv
`timescale 1ns/1ps
module tb_regwin_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_ni = 1'b1;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  strap_i = '0;
  logic [1:0]  bus_mode_i = '0;
  logic        ext_ni = 1'b1;
  logic        oe_o;
  logic [63:0] wr_en_o;
  logic [5:0]  reg_idx_o;
  logic [7:0]  rd_mask_o;
  logic        mux_mode_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  regwin_decoder dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(logic sel_n, logic [7:0] a, logic [2:0] s,
                                   logic [1:0] bm, logic ext_n);
    bit win, ok;
    win = ext_n ? (a[7:5] == s) : (a[7:6] == s[2:1]);
    ok  = !(ext_n && a[5:0] >= 6'h25) && !(bm == 2'b11 && a[5:0] >= 6'h20);
    return !sel_n && win && ok;
  endfunction

  task automatic access(string req, logic sel_n, logic [7:0] a, bit rd, bit wr);
    bit h;
    @(negedge clk_i);
    sel_ni = sel_n; addr_i = a; rd_i = rd; wr_i = wr;
    #1;
    chk("R11", {63'd0, oe_o}, 64'd0);
    h = model_hit(sel_n, a, strap_i, bus_mode_i, ext_ni);
    @(negedge clk_i);
    chk(req, {63'd0, oe_o}, {63'd0, h && rd});
    chk(req, wr_en_o, (h && wr) ? (64'd1 << a[5:0]) : 64'd0);
    chk(req, {58'd0, reg_idx_o}, (h && (rd || wr)) ? {58'd0, a[5:0]} : 64'd0);
    chk("R10", {56'd0, rd_mask_o}, (h && rd && a[5:0] == 6'h10) ? 64'h7F : 64'hFF);
    sel_ni = 1'b1; rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk_i);
    chk("R1", {63'd0, oe_o}, 0);
    chk("R1", wr_en_o, 0);
    chk("R1", {58'd0, reg_idx_o}, 0);
    chk("R1", {56'd0, rd_mask_o}, 64'hFF);
    chk("R1", {63'd0, mux_mode_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_chip_sel;
    ext_ni = 1'b0; strap_i = 3'b000; bus_mode_i = 2'b00;
    access("R2", 1'b1, 8'h05, 1, 0);
    access("R2", 1'b1, 8'h05, 0, 1);
    access("R9", 1'b0, 8'h05, 1, 0);
    access("R9", 1'b0, 8'h05, 0, 1);
  endtask

  task automatic t_ext_windows;
    ext_ni = 1'b0;
    for (int s = 0; s < 8; s++) begin
      strap_i = 3'(s);
      access("R3", 1'b0, {strap_i[2:1], 6'h2A}, 0, 1);
      access("R3", 1'b0, {strap_i[2:1], 6'h03}, 1, 0);
      access("R5", 1'b0, {~strap_i[2:1], 6'h03}, 1, 1);
    end
  endtask

  task automatic t_legacy_windows;
    ext_ni = 1'b1; bus_mode_i = 2'b00;
    for (int s = 0; s < 8; s++) begin
      strap_i = 3'(s);
      access("R4", 1'b0, {strap_i, 5'h04}, 1, 0);
      access("R5", 1'b0, {strap_i[2:1], ~strap_i[0], 5'h04}, 1, 1);
    end
    strap_i = 3'b001;
    access("R6", 1'b0, 8'h24, 0, 1);
    access("R6", 1'b0, 8'h25, 0, 1);
    access("R6", 1'b0, 8'h3F, 1, 0);
  endtask

  task automatic t_bus_modes;
    ext_ni = 1'b0; strap_i = 3'b010;
    bus_mode_i = 2'b11;
    access("R7", 1'b0, 8'h5F, 1, 0);
    access("R7", 1'b0, 8'h60, 1, 0);
    access("R7", 1'b0, 8'h7F, 0, 1);
    chk("R8", {63'd0, mux_mode_o}, 0);
    bus_mode_i = 2'b10;
    access("R8", 1'b0, 8'h60, 1, 0);
    access("R8", 1'b0, 8'h7F, 0, 1);
    chk("R8", {63'd0, mux_mode_o}, 1);
    bus_mode_i = 2'b01;
    @(negedge clk_i);
    chk("R8", {63'd0, mux_mode_o}, 0);
  endtask

  task automatic t_bit7;
    ext_ni = 1'b0; strap_i = 3'b000; bus_mode_i = 2'b00;
    access("R10", 1'b0, 8'h10, 1, 0);
    access("R10", 1'b0, 8'h11, 1, 0);
    access("R10", 1'b0, 8'h10, 0, 1);
    ext_ni = 1'b1;
    access("R10", 1'b0, 8'h10, 1, 0);
  endtask

  task automatic t_sweep;
    for (int cfg = 0; cfg < 4; cfg++) begin
      ext_ni = cfg[0]; bus_mode_i = cfg[1] ? 2'b11 : 2'b10; strap_i = 3'b101;
      for (int a = 0; a < 256; a++) access("R5", 1'b0, 8'(a), a[0], ~a[0]);
    end
  endtask

  initial begin
    t_reset;
    t_chip_sel;
    t_ext_windows;
    t_legacy_windows;
    t_bus_modes;
    t_bit7;
    t_sweep;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule